// File: doc/BRIEF.md
# Gapped-Clock Jitter Smoother

This block turns a bursty, gapped bit stream into an evenly paced one. Every channel's input bits arrive with a one-cycle strobe. These strobes may come in quick bursts and then stop for a while. Each bit that passes through the smoother is written into a circular bit buffer. The buffer is read by a numerically controlled oscillator, which is a phase accumulator clocked by the fast reference clock. Each accumulator carry produces one output strobe. The accumulator increment is a nominal value plus a correction proportional to how far the buffer fill sits from its centre point. This is a first-order loop with no integrator. It pulls the read rate toward the long-term average write rate without overshoot, and it keeps the fill near the centre.

A single pair of global select inputs decides where the smoother sits for all channels at once. One input places it in the receive path and the other in the transmit path. When both or neither are set, the smoother is out of circuit. A channel whose power-down input is set always passes both of its paths straight through. Any path that is not being smoothed reaches its output with no register in the way. When the fill leaves its legal window, the channel raises a sticky slip flag and the read pointer is placed back at the centre distance.

Top module: `jit_smoother`

## Requirements
- R1: With sel_rx=1 and sel_tx=0, every channel with pd=0 carries its receive stream through the buffer, and every transmit output equals its transmit input in the same cycle.
- R2: With sel_tx=1 and sel_rx=0, every channel with pd=0 carries its transmit stream through the buffer, and every receive output equals its receive input in the same cycle.
- R3: With sel_rx and sel_tx both 1 or both 0, all four outputs of every channel equal the matching inputs in the same cycle, and slip_err stays 0.
- R4: A channel with pd[c]=1 passes both paths straight through in the same cycle whatever the select inputs are, and its slip_err bit reads 0 from the next cycle on.
- R5: After reset and activation, a smoothed channel emits CENTER (default 33) zero bits and then the input bits in arrival order, with none lost or repeated while the fill stays within 0 to LIMIT (default 66).
- R6: The output strobe of a smoothed path is one cycle wide. With the default increment (1/8 of the accumulator range) and input whose long-term average is one bit per 8 reference cycles, successive strobes are 7 to 9 reference cycles apart.
- R7: If a write would take the fill above LIMIT, slip_err for that channel goes to 1, the read pointer is set back to CENTER behind the write pointer, and the flag holds while the channel stays active.
- R8: If a read is due while the buffer is empty, slip_err for that channel goes to 1.
- R9: slip_err is 0 after reset, and it returns to 0 one cycle after its channel stops being smoothed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock; all timing derives from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_rx | input | 1 | Global select: smooth the receive paths |
| sel_tx | input | 1 | Global select: smooth the transmit paths |
| pd | input | NCH | Per-channel power-down; forces pass-through |
| rx_in_bit | input | NCH | Receive data bit per channel |
| rx_in_en | input | NCH | Receive bit strobe per channel (may be gapped) |
| tx_in_bit | input | NCH | Transmit data bit per channel |
| tx_in_en | input | NCH | Transmit bit strobe per channel (may be gapped) |
| rx_out_bit | output | NCH | Receive data out |
| rx_out_en | output | NCH | Receive strobe out |
| tx_out_bit | output | NCH | Transmit data out |
| tx_out_en | output | NCH | Transmit strobe out |
| slip_err | output | NCH | Sticky buffer over/underflow flag per channel |

## Verification
The strobe-spacing property assumes that the fill never leaves the 0 to LIMIT window. That bounds the increment between its minimum and maximum, and so it bounds the gap between carries. The pass-through properties assume that the select and power-down inputs are held steady within a cycle. The stimulus changes the selects only between test phases. In the data phase it sends three bits every 24 cycles in short bursts, which is exactly the nominal average rate, so the fill only moves by a few entries. Overflow and underflow are produced on purpose, by sending a strobe on every cycle and by stopping the input entirely.

// File: rtl/jit_smoother.sv
module jit_smoother #(
  parameter int NCH     = 4,
  parameter int AW      = 7,
  parameter int CENTER  = 33,
  parameter int LIMIT   = 66,
  parameter int ACC_W   = 16,
  parameter int NOM_INC = 8192,
  parameter int LOOP_SH = 12
) (
  input  logic           clk_ref,
  input  logic           rst_n,
  input  logic           sel_rx,
  input  logic           sel_tx,
  input  logic [NCH-1:0] pd,
  input  logic [NCH-1:0] rx_in_bit,
  input  logic [NCH-1:0] rx_in_en,
  input  logic [NCH-1:0] tx_in_bit,
  input  logic [NCH-1:0] tx_in_en,
  output logic [NCH-1:0] rx_out_bit,
  output logic [NCH-1:0] rx_out_en,
  output logic [NCH-1:0] tx_out_bit,
  output logic [NCH-1:0] tx_out_en,
  output logic [NCH-1:0] slip_err
);
  localparam int DEPTH   = 1 << AW;
  localparam int CORR_SH = ACC_W - LOOP_SH;

  logic att_on;
  assign att_on = sel_rx ^ sel_tx;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic             act, act_q, in_b, in_e, we, rd, slip, oe, ob, err;
    logic [DEPTH-1:0] mem;
    logic [AW-1:0]    wp, rp, fill, fill_nxt, wp_nxt;
    logic [ACC_W-1:0] acc, corr, inc;
    logic [ACC_W:0]   sum;

    assign act  = att_on & ~pd[c];
    assign in_b = sel_rx ? rx_in_bit[c] : tx_in_bit[c];
    assign in_e = sel_rx ? rx_in_en[c]  : tx_in_en[c];

    assign fill     = wp - rp;
    assign corr     = (ACC_W'(fill) - ACC_W'(CENTER)) << CORR_SH;
    assign inc      = ACC_W'(NOM_INC) + corr;
    assign sum      = {1'b0, acc} + {1'b0, inc};
    assign we       = act & in_e;
    assign rd       = act & act_q & sum[ACC_W];
    assign wp_nxt   = wp + AW'(we);
    assign fill_nxt = fill + AW'(we) - AW'(rd);
    assign slip     = act & act_q & (fill_nxt > AW'(LIMIT));

    always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
        mem   <= '0;
        wp    <= '0;
        rp    <= AW'(DEPTH - CENTER);
        acc   <= '0;
        act_q <= 1'b0;
        oe    <= 1'b0;
        ob    <= 1'b0;
        err   <= 1'b0;
      end else begin
        act_q <= act;
        oe    <= rd;
        if (we) begin
          mem[wp] <= in_b;
          wp      <= wp_nxt;
        end
        if (rd) ob <= mem[rp];
        if (!act) begin
          acc <= '0;
          err <= 1'b0;
        end else if (!act_q) begin
          acc <= '0;
          rp  <= wp_nxt - AW'(CENTER);
        end else begin
          acc <= sum[ACC_W-1:0];
          if (slip) begin
            rp  <= wp_nxt - AW'(CENTER);
            err <= 1'b1;
          end else if (rd) begin
            rp <= rp + 1'b1;
          end
        end
      end
    end

    assign rx_out_bit[c] = (act & sel_rx) ? ob : rx_in_bit[c];
    assign rx_out_en[c]  = (act & sel_rx) ? oe : rx_in_en[c];
    assign tx_out_bit[c] = (act & sel_tx) ? ob : tx_in_bit[c];
    assign tx_out_en[c]  = (act & sel_tx) ? oe : tx_in_en[c];
    assign slip_err[c]   = err;
  end
endmodule

module jit_smoother_chk #(
  parameter int NCH     = 4,
  parameter int CENTER  = 33,
  parameter int ACC_W   = 16,
  parameter int NOM_INC = 8192,
  parameter int LOOP_SH = 12
) (
  input logic           clk_ref,
  input logic           rst_n,
  input logic           sel_rx,
  input logic           sel_tx,
  input logic [NCH-1:0] pd,
  input logic [NCH-1:0] rx_in_bit,
  input logic [NCH-1:0] rx_in_en,
  input logic [NCH-1:0] tx_in_bit,
  input logic [NCH-1:0] tx_in_en,
  input logic [NCH-1:0] rx_out_bit,
  input logic [NCH-1:0] rx_out_en,
  input logic [NCH-1:0] tx_out_bit,
  input logic [NCH-1:0] tx_out_en,
  input logic [NCH-1:0] slip_err
);
  localparam int MINSTEP = NOM_INC - (CENTER << (ACC_W - LOOP_SH));
  localparam int MAXGAP  = ((1 << ACC_W) + MINSTEP - 1) / MINSTEP + 2;

  p_bypass_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !(sel_rx ^ sel_tx) |-> (rx_out_bit == rx_in_bit && rx_out_en == rx_in_en &&
                            tx_out_bit == tx_in_bit && tx_out_en == tx_in_en));
  p_tx_pass_r1: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (sel_rx && !sel_tx) |-> (tx_out_bit == tx_in_bit && tx_out_en == tx_in_en));
  p_rx_pass_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (sel_tx && !sel_rx) |-> (rx_out_bit == rx_in_bit && rx_out_en == rx_in_en));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    logic       act_c, sen, act_d;
    logic [7:0] gap;
    assign act_c = (sel_rx ^ sel_tx) & ~pd[c];
    assign sen   = sel_rx ? rx_out_en[c] : tx_out_en[c];

    always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
        act_d <= 1'b0;
        gap   <= '0;
      end else begin
        act_d <= act_c;
        if (!act_c || sen) gap <= '0;
        else if (gap != 8'hff) gap <= gap + 1'b1;
      end
    end

    p_pd_pass_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
      pd[c] |-> (rx_out_bit[c] == rx_in_bit[c] && rx_out_en[c] == rx_in_en[c] &&
                 tx_out_bit[c] == tx_in_bit[c] && tx_out_en[c] == tx_in_en[c]));
    p_single_strobe_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (act_c && act_d && sen) |=> !(act_c && sen));
    p_gap_bound_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
      int'(gap) <= MAXGAP);
    p_slip_hold_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (act_c && slip_err[c]) |=> slip_err[c]);
    p_slip_clear_r9: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !act_c |=> !slip_err[c]);
  end
endmodule

bind jit_smoother jit_smoother_chk #(
  .NCH(NCH), .CENTER(CENTER), .ACC_W(ACC_W), .NOM_INC(NOM_INC), .LOOP_SH(LOOP_SH)
) chk_i (
  .clk_ref(clk_ref), .rst_n(rst_n), .sel_rx(sel_rx), .sel_tx(sel_tx), .pd(pd),
  .rx_in_bit(rx_in_bit), .rx_in_en(rx_in_en), .tx_in_bit(tx_in_bit), .tx_in_en(tx_in_en),
  .rx_out_bit(rx_out_bit), .rx_out_en(rx_out_en), .tx_out_bit(tx_out_bit),
  .tx_out_en(tx_out_en), .slip_err(slip_err)
);

// File: tb/jit_smoother_tb.sv
module jit_smoother_tb_top;
  localparam int NCH = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n, sel_rx, sel_tx;
  logic [NCH-1:0] pd, rx_in_bit, rx_in_en, tx_in_bit, tx_in_en;
  logic [NCH-1:0] rx_out_bit, rx_out_en, tx_out_bit, tx_out_en, slip_err;

  jit_smoother dut_i (
    .clk_ref(clk), .rst_n(rst_n), .sel_rx(sel_rx), .sel_tx(sel_tx), .pd(pd),
    .rx_in_bit(rx_in_bit), .rx_in_en(rx_in_en), .tx_in_bit(tx_in_bit), .tx_in_en(tx_in_en),
    .rx_out_bit(rx_out_bit), .rx_out_en(rx_out_en), .tx_out_bit(tx_out_bit),
    .tx_out_en(tx_out_en), .slip_err(slip_err)
  );

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  always @(posedge clk) cyc++;

  bit             exp_q[NCH][$];
  int             last_t[NCH];
  logic           mon_on = 1'b0;
  logic [NCH-1:0] att_mask = '0;
  logic [15:0]    lf[NCH];

  task automatic chk(input bit ok, input string req, input string what, input int a, input int e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, a, e);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // scoreboard monitor: pops expected bits on each smoothed receive strobe
  always @(negedge clk) begin
    if (mon_on) begin
      for (int c = 0; c < NCH; c++) begin
        if (att_mask[c] && rx_out_en[c] && exp_q[c].size() > 0) begin
          bit e;
          e = exp_q[c].pop_front();
          chk(rx_out_bit[c] == e, "R5", "smoothed bit", int'(rx_out_bit[c]), int'(e));
          if (last_t[c] >= 0)
            chk((cyc - last_t[c]) >= 7 && (cyc - last_t[c]) <= 9, "R6", "strobe spacing",
                cyc - last_t[c], 8);
          last_t[c] = cyc;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; sel_rx = 1'b0; sel_tx = 1'b0; pd = '0;
    rx_in_bit = '0; rx_in_en = '0; tx_in_bit = '0; tx_in_en = '0;
    for (int c = 0; c < NCH; c++) begin
      lf[c] = 16'hACE1 + 16'(c * 977);
      last_t[c] = -1;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    chk(slip_err == 0, "R9", "slip_err after reset", int'(slip_err), 0);
    rx_in_bit = 4'b1010; rx_in_en = 4'b0110; tx_in_bit = 4'b0011; tx_in_en = 4'b1001;
    #1;
    chk(rx_out_bit == rx_in_bit && rx_out_en == rx_in_en, "R3", "rx bypass none selected",
        int'({rx_out_bit, rx_out_en}), int'({rx_in_bit, rx_in_en}));
    chk(tx_out_bit == tx_in_bit && tx_out_en == tx_in_en, "R3", "tx bypass none selected",
        int'({tx_out_bit, tx_out_en}), int'({tx_in_bit, tx_in_en}));

    // receive path smoothed, channel 2 powered down
    @(posedge clk); #1;
    rx_in_en = '0; tx_in_en = '0;
    pd = 4'b0100; sel_rx = 1'b1; att_mask = 4'b1011;
    for (int c = 0; c < NCH; c++)
      if (att_mask[c]) for (int i = 0; i < 33; i++) exp_q[c].push_back(1'b0);
    mon_on = 1'b1;
    @(posedge clk); #1;
    for (int f = 0; f < 100; f++) begin
      for (int k = 0; k < 24; k++) begin
        bit strobe;
        strobe = (k == 0 || k == 2 || k == 4);
        for (int c = 0; c < NCH; c++) begin
          if (strobe) begin
            rx_in_bit[c] = lf[c][0];
            if (att_mask[c]) exp_q[c].push_back(lf[c][0]);
            lf[c] = {lf[c][0] ^ lf[c][2] ^ lf[c][3] ^ lf[c][5], lf[c][15:1]};
          end
        end
        rx_in_en  = strobe ? 4'hF : 4'h0;
        tx_in_bit = 4'($urandom);
        tx_in_en  = 4'($urandom);
        #1;
        if (k < 2) begin
          chk(tx_out_bit == tx_in_bit && tx_out_en == tx_in_en, "R1", "tx passes when rx selected",
              int'({tx_out_bit, tx_out_en}), int'({tx_in_bit, tx_in_en}));
          chk(rx_out_bit[2] == rx_in_bit[2] && rx_out_en[2] == rx_in_en[2], "R4",
              "powered-down channel passes", int'({rx_out_bit[2], rx_out_en[2]}),
              int'({rx_in_bit[2], rx_in_en[2]}));
        end
        @(posedge clk); #1;
      end
    end
    rx_in_en = '0; tx_in_en = '0;
    repeat (1200) @(posedge clk);
    #1;
    for (int c = 0; c < NCH; c++)
      if (att_mask[c]) chk(exp_q[c].size() == 0, "R5", "all bits delivered", exp_q[c].size(), 0);
    chk(slip_err == 4'b1011, "R8", "underflow flags", int'(slip_err), 11);
    mon_on = 1'b0;

    // leave smoothing: flags clear next cycle
    sel_rx = 1'b0;
    @(posedge clk); #1;
    chk(slip_err == 0, "R9", "flags cleared on exit", int'(slip_err), 0);

    // transmit path smoothed, overflow by continuous strobes
    sel_tx = 1'b1; pd = '0;
    @(posedge clk); #1;
    for (int i = 0; i < 150; i++) begin
      tx_in_en  = 4'hF;
      tx_in_bit = 4'($urandom);
      rx_in_bit = 4'($urandom);
      rx_in_en  = 4'($urandom);
      #1;
      if (i % 10 == 0)
        chk(rx_out_bit == rx_in_bit && rx_out_en == rx_in_en, "R2", "rx passes when tx selected",
            int'({rx_out_bit, rx_out_en}), int'({rx_in_bit, rx_in_en}));
      @(posedge clk); #1;
    end
    tx_in_en = '0;
    chk(slip_err == 4'hF, "R7", "overflow flags", int'(slip_err), 15);
    @(posedge clk); #1;
    chk(slip_err == 4'hF, "R7", "overflow flags hold", int'(slip_err), 15);

    // power down one channel while transmit smoothing is on
    pd = 4'b0010;
    @(posedge clk); #1;
    chk(slip_err == 4'b1101, "R4", "powered-down flag cleared", int'(slip_err), 13);
    tx_in_bit = 4'b0010; tx_in_en = 4'b0010;
    #1;
    chk(tx_out_bit[1] == 1'b1 && tx_out_en[1] == 1'b1, "R4", "powered-down tx passes",
        int'({tx_out_bit[1], tx_out_en[1]}), 3);

    // both selects set: smoother out of circuit
    sel_rx = 1'b1;
    @(posedge clk); #1;
    chk(slip_err == 0, "R3", "flags clear with both selects", int'(slip_err), 0);
    rx_in_bit = 4'b0110; rx_in_en = 4'b1100; tx_in_bit = 4'b1001; tx_in_en = 4'b0101;
    #1;
    chk(rx_out_bit == rx_in_bit && rx_out_en == rx_in_en, "R3", "rx bypass both selected",
        int'({rx_out_bit, rx_out_en}), int'({rx_in_bit, rx_in_en}));
    chk(tx_out_bit == tx_in_bit && tx_out_en == tx_in_en, "R3", "tx bypass both selected",
        int'({tx_out_bit, tx_out_en}), int'({tx_in_bit, tx_in_en}));

    summary();
    $finish;
  end
endmodule